// File: doc/BRIEF.md
# I2S-to-PWM Audio Modulator

The block receives a stereo stream of 24-bit two's-complement PCM over a three-wire I2S link and turns it into pulse-width-modulated drive for a power stage. The whole block runs on the master clock, which is 256 times the sample rate. The serial clock, word select and data lines are brought into that domain through synchronisers. A free-running 32-clock counter forms the PWM carrier, so each sample period holds eight carrier periods. The output amplitude therefore follows the sample value alone, whatever the sample rate.

Each channel maps its sample to offset binary. It adds a pseudo-random dither and the error left over from the previous carrier period, and keeps the top five bits as the high-time count for the next period. A held sample is used again until a new word arrives.

Two output pins serve either two single-ended channels or one bridged channel. In bridge mode the second pin is the complement of the first, and a select input picks the source channel. The mode and the select are captured only while standby is asserted. Mute forces a half-duty carrier. Standby drives both pins low.

Top module: `i2s_pwm_mod`

## Requirements
- R1: While standby is high, both PWM outputs are low from the clock after it is seen. Standby also clears each channel's error memory. During reset both outputs are low.
- R2: On every rising serial-clock edge the data bit is shifted in. Each slot is 32 bits long, MSB first, and begins one serial clock after a word-select change. Word select low marks the left slot and high marks the right slot. The upper 24 bits of a slot form the sample.
- R3: The sample is made offset binary by inverting its top bit. Each 32-clock carrier period is high for a count of 0..31 clocks. With error feedback, the long-run high fraction equals offset/2^24 plus the dither bias.
- R4: When the sum overflows 24 bits, the count saturates at 31 (31 high clocks in 32). The most negative sample gives a count of 0, apart from the dither carries.
- R5: In stereo mode (mode input 0), output A carries the left channel and output B the right channel.
- R6: In bridge mode (mode input 1), output B is the exact complement of output A. Output A carries the right channel when the select input is 1 and the left channel when it is 0.
- R7: The mode and select inputs take effect only while standby is high. Changes while running have no effect.
- R8: Mute forces a count of 16 on both channels from the next carrier period, so any 32-clock window holds exactly 16 high clocks.
- R9: The dither comes from an 18-bit field of a 20-bit LFSR (x^20+x^17+1) that steps once per carrier period. It is shifted right by 3 minus the 2-bit level, so level 00 spans 2^15 and level 11 spans 2^18 sample LSBs. Level 11 raises the mid-scale high count measurably above level 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256 times the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| i2s_sck | input | 1 | I2S serial clock |
| i2s_ws | input | 1 | I2S word select (0 left, 1 right) |
| i2s_sd | input | 1 | I2S serial data |
| bridge_en | input | 1 | 0 two single-ended channels, 1 bridged |
| bridge_sel_right | input | 1 | Bridge source: 1 right, 0 left |
| dither_lvl | input | 2 | Dither level 00 low to 11 high |
| mute | input | 1 | Force half-duty carrier |
| standby | input | 1 | Hold outputs low, capture mode |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
Two of the block's functions can meet in one cycle: a new I2S word lands in the sample register while a carrier period begins and the quantiser loads it. Mute can also be raised while quantised counts are being loaded. The I2S stream runs on continuously, so word arrivals sweep across every carrier phase. Each case is judged by how many clocks the outputs spend high over long windows, against values derived from the offset mapping and the dither bias. Under mute the count must be exactly half of any window. In bridge mode the two outputs are compared clock by clock for exact complement.

// File: rtl/i2s_pwm_pkg.sv
package i2s_pwm_pkg;
  localparam int SAMPLE_W = 24;
  localparam int DUTY_W   = 5;
  localparam int SLOT_W   = 32;
  localparam int LFSR_W   = 20;
  localparam int STEP_W   = SAMPLE_W - DUTY_W;
  localparam int DITH_W   = STEP_W - 1;
  localparam int NCH      = 2;
  localparam logic [DUTY_W-1:0] DUTY_MID = DUTY_W'(1 << (DUTY_W - 1));

  typedef struct packed {
    logic [DUTY_W-1:0] duty;
    logic [STEP_W-1:0] err;
  } quant_t;

  function automatic logic [SAMPLE_W-1:0] to_offset(input logic [SAMPLE_W-1:0] s);
    return {~s[SAMPLE_W-1], s[SAMPLE_W-2:0]};
  endfunction

  function automatic logic [DITH_W-1:0] scale_dither(input logic [DITH_W-1:0] raw,
                                                     input logic [1:0] lvl);
    return raw >> (2'd3 - lvl);
  endfunction

  function automatic quant_t quantise(input logic [SAMPLE_W-1:0] u,
                                      input logic [STEP_W-1:0] err,
                                      input logic [DITH_W-1:0] dith);
    quant_t q;
    logic [SAMPLE_W:0] acc;
    acc = {1'b0, u} + {{(DUTY_W+1){1'b0}}, err} + {{(DUTY_W+2){1'b0}}, dith};
    if (acc[SAMPLE_W]) begin
      q.duty = '1;
      q.err  = '1;
    end else begin
      q.duty = acc[SAMPLE_W-1:STEP_W];
      q.err  = acc[STEP_W-1:0];
    end
    return q;
  endfunction
endpackage

// File: rtl/i2s_rx.sv
module i2s_rx
  import i2s_pwm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck,
  input  logic                ws,
  input  logic                sd,
  output logic [SAMPLE_W-1:0] left_q,
  output logic [SAMPLE_W-1:0] right_q,
  output logic                left_stb,
  output logic                right_stb
);
  logic [1:0] sck_sy, ws_sy, sd_sy;
  logic       sck_d, ws_prev;
  logic [SLOT_W-1:0] shreg;
  logic [SLOT_W-1:0] word;
  logic       sck_rise, slot_end;

  assign sck_rise  = sck_sy[1] & ~sck_d;
  assign word      = {shreg[SLOT_W-2:0], sd_sy[1]};
  assign slot_end  = sck_rise && (ws_sy[1] != ws_prev);
  assign left_stb  = slot_end && !ws_prev;
  assign right_stb = slot_end && ws_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_sy <= '0; ws_sy <= '0; sd_sy <= '0; sck_d <= 1'b0;
    end else begin
      sck_sy <= {sck_sy[0], sck};
      ws_sy  <= {ws_sy[0], ws};
      sd_sy  <= {sd_sy[0], sd};
      sck_d  <= sck_sy[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0; ws_prev <= 1'b0; left_q <= '0; right_q <= '0;
    end else if (sck_rise) begin
      shreg   <= word;
      ws_prev <= ws_sy[1];
      if (left_stb)  left_q  <= word[SLOT_W-1 -: SAMPLE_W];
      if (right_stb) right_q <= word[SLOT_W-1 -: SAMPLE_W];
    end
  end

  AST_WORD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (left_stb || right_stb) |=> !(left_stb || right_stb)); // R2
endmodule

// File: rtl/pwm_quant.sv
module pwm_quant
  import i2s_pwm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                standby,
  input  logic                load,
  input  logic                mute,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [DITH_W-1:0]   dither_raw,
  input  logic [1:0]          lvl,
  output logic [DUTY_W-1:0]   duty_o
);
  logic [STEP_W-1:0] err_q;
  quant_t            q;

  always_comb q = quantise(to_offset(sample), err_q, scale_dither(dither_raw, lvl));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= '0;
      duty_o <= '0;
    end else if (standby) begin
      err_q  <= '0;
      duty_o <= '0;
    end else if (load) begin
      err_q  <= q.err;
      duty_o <= mute ? DUTY_MID : q.duty;
    end
  end

  AST_MUTE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (load && mute && !standby) |=> (duty_o == DUTY_MID)); // R8
  AST_STBY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (err_q == '0)); // R1
endmodule

// File: rtl/i2s_pwm_mod.sv
module i2s_pwm_mod
  import i2s_pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       i2s_sck,
  input  logic       i2s_ws,
  input  logic       i2s_sd,
  input  logic       bridge_en,
  input  logic       bridge_sel_right,
  input  logic [1:0] dither_lvl,
  input  logic       mute,
  input  logic       standby,
  output logic       pwm_a,
  output logic       pwm_b
);
  logic [SAMPLE_W-1:0] smp [NCH];
  logic [DUTY_W-1:0]   duty [NCH];
  logic [DITH_W-1:0]   draw [NCH];
  logic [NCH-1:0]      hi;
  logic [DUTY_W-1:0]   cnt;
  logic [LFSR_W-1:0]   lfsr;
  logic                period_start;
  logic                bridge_q, sel_q;
  logic                left_stb, right_stb;
  logic                nxt_a, nxt_b;

  i2s_rx u_rx (
    .clk(clk), .rst_n(rst_n), .sck(i2s_sck), .ws(i2s_ws), .sd(i2s_sd),
    .left_q(smp[0]), .right_q(smp[1]), .left_stb(left_stb), .right_stb(right_stb)
  );

  assign period_start = &cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      lfsr <= LFSR_W'(1);
    end else begin
      cnt <= cnt + 1'b1;
      if (period_start) lfsr <= {lfsr[LFSR_W-2:0], lfsr[LFSR_W-1] ^ lfsr[16]};
    end
  end

  assign draw[0] = lfsr[DITH_W-1:0];
  assign draw[1] = lfsr[LFSR_W-1 -: DITH_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bridge_q <= 1'b0;
      sel_q    <= 1'b0;
    end else if (standby) begin
      bridge_q <= bridge_en;
      sel_q    <= bridge_sel_right;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_quant u_q (
      .clk(clk), .rst_n(rst_n), .standby(standby), .load(period_start),
      .mute(mute), .sample(smp[c]), .dither_raw(draw[c]), .lvl(dither_lvl),
      .duty_o(duty[c])
    );
    assign hi[c] = (cnt < duty[c]);
  end

  assign nxt_a = bridge_q ? (sel_q ? hi[1] : hi[0]) : hi[0];
  assign nxt_b = bridge_q ? ~nxt_a : hi[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_a <= 1'b0;
      pwm_b <= 1'b0;
    end else begin
      pwm_a <= !standby && nxt_a;
      pwm_b <= !standby && nxt_b;
    end
  end

  AST_STBY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (!pwm_a && !pwm_b)); // R1
  AST_BRIDGE_COMP: assert property (@(posedge clk) disable iff (!rst_n)
    (bridge_q && !$past(standby)) |-> (pwm_b == !pwm_a)); // R6
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !standby |=> ($stable(bridge_q) && $stable(sel_q))); // R7
endmodule

// File: tb/i2s_pwm_mod_tb.sv
module i2s_pwm_mod_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, ws = 1'b0, sd = 1'b0;
  logic bridge_en = 1'b0, sel_r = 1'b0;
  logic [1:0] lvl = 2'b00;
  logic mute = 1'b0, standby = 1'b1;
  logic pwm_a, pwm_b;
  logic [23:0] l_val = 24'h0, r_val = 24'h0;
  int n_chk = 0, n_fail = 0;
  int ca, cb, mism;

  always #4 clk = ~clk;

  i2s_pwm_mod dut_i (
    .clk(clk), .rst_n(rst_n), .i2s_sck(sck), .i2s_ws(ws), .i2s_sd(sd),
    .bridge_en(bridge_en), .bridge_sel_right(sel_r), .dither_lvl(lvl),
    .mute(mute), .standby(standby), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  // I2S source: 64 serial clocks per frame, 4 master clocks per serial clock
  initial begin
    forever begin
      for (int i = 0; i < 64; i++) begin
        logic [31:0] lw, rw;
        lw = {l_val, 8'h00};
        rw = {r_val, 8'h00};
        @(posedge clk); #1;
        sck = 1'b0;
        ws  = (i >= 32);
        if (i == 0)       sd = rw[0];
        else if (i < 32)  sd = lw[32-i];
        else if (i == 32) sd = lw[0];
        else              sd = rw[64-i];
        @(posedge clk);
        @(posedge clk); #1;
        sck = 1'b1;
        @(posedge clk);
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    chk(act >= lo && act <= hi, tag, act, (lo + hi) / 2);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic measure(input int n);
    ca = 0; cb = 0; mism = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ca += int'(pwm_a);
      cb += int'(pwm_b);
      if (pwm_a == pwm_b) mism++;
    end
  endtask

  task automatic t_reset;
    wait_clk(3);
    @(negedge clk);
    chk(pwm_a == 1'b0, "R1 reset A", int'(pwm_a), 0);
    chk(pwm_b == 1'b0, "R1 reset B", int'(pwm_b), 0);
    @(negedge clk) rst_n = 1'b1;
    measure(256);
    chk(ca == 0, "R1 standby A", ca, 0);
    chk(cb == 0, "R1 standby B", cb, 0);
  endtask

  // offsets: +0x400000 -> 0.75 of 4096 = 3072, -0x400000 -> 1024, level 00 adds ~4
  task automatic t_stereo;
    l_val = 24'h400000; r_val = 24'hC00000; lvl = 2'b00;
    @(negedge clk) standby = 1'b0;
    wait_clk(1200);
    measure(4096);
    chk_rng("R5 R2 R3 stereo left on A", ca, 3064, 3088);
    chk_rng("R5 R2 R3 stereo right on B", cb, 1016, 1040);
  endtask

  task automatic t_fullscale;
    l_val = 24'h7FFFFF; r_val = 24'h800000;
    wait_clk(1200);
    measure(4096);
    chk_rng("R4 positive saturation 31/32", ca, 3960, 3972);
    chk_rng("R4 most negative near zero", cb, 0, 12);
  endtask

  task automatic t_mute;
    @(negedge clk) mute = 1'b1;
    wait_clk(100);
    measure(256);
    chk(ca == 128, "R8 mute A half", ca, 128);
    chk(cb == 128, "R8 mute B half", cb, 128);
    @(negedge clk) mute = 1'b0;
  endtask

  // mid-scale: base 2048 of 4096; level 11 bias ~+32, level 00 ~+4
  task automatic t_dither;
    int lo_cnt;
    l_val = 24'h000000; r_val = 24'h000000; lvl = 2'b00;
    wait_clk(1200);
    measure(4096);
    lo_cnt = ca;
    chk_rng("R9 level 00 mid-scale", ca, 2044, 2062);
    lvl = 2'b11;
    wait_clk(1200);
    measure(4096);
    chk_rng("R9 level 11 mid-scale", ca, 2068, 2096);
    chk(ca > lo_cnt + 6, "R9 level 11 above level 00", ca, lo_cnt + 7);
    lvl = 2'b00;
  endtask

  task automatic t_bridge;
    @(negedge clk) begin standby = 1'b1; bridge_en = 1'b1; sel_r = 1'b1; end
    wait_clk(2);
    measure(256);
    chk(ca == 0 && cb == 0, "R1 standby while running", ca + cb, 0);
    l_val = 24'h400000; r_val = 24'hC00000;
    wait_clk(600);
    @(negedge clk) standby = 1'b0;
    wait_clk(1200);
    measure(4096);
    chk_rng("R6 bridge right on A", ca, 1016, 1040);
    chk(mism == 0, "R6 bridge complement", mism, 0);
    // change mode pins while running: must be ignored
    @(negedge clk) begin bridge_en = 1'b0; sel_r = 1'b0; end
    wait_clk(600);
    measure(4096);
    chk_rng("R7 mode held A still right", ca, 1016, 1040);
    chk(mism == 0, "R7 mode held still bridged", mism, 0);
    @(negedge clk) begin standby = 1'b1; bridge_en = 1'b1; sel_r = 1'b0; end
    wait_clk(10);
    @(negedge clk) standby = 1'b0;
    wait_clk(1200);
    measure(4096);
    chk_rng("R6 bridge left on A", ca, 3064, 3088);
    chk(cb == 4096 - ca, "R6 bridge B complement count", cb, 4096 - ca);
  endtask

  initial begin
    t_reset();
    t_stereo();
    t_fullscale();
    t_mute();
    t_dither();
    t_bridge();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule